// File: doc/BRIEF.md
# Windowed Receive FIFO with Idle Timeout

This block is the receive-side byte store of a high-rate serial port. A deserialiser delivers one byte per strobe; the bytes are held in a 1024-entry circular buffer. Software does not pop bytes one at a time. It reads the fill count, fetches bytes through a memory window whose first byte lane (offset 4) always maps to the oldest unread byte, and then writes how many bytes it consumed. That single write releases the bytes, advances the read pointer and lowers the fill count.

Two events support interrupt-driven draining. The data-available flag is set while the fill count is at or above a trigger level chosen by a 3-bit code. The character-timeout flag covers a trickle of data that never reaches that level. An idle timer runs while the buffer holds some bytes but fewer than the trigger level. When it reaches the programmed limit without a new byte or acknowledge, the flag is raised.

The idle timer is a three-state machine. It has the states TMR_IDLE (disarmed), TMR_RUN (counting) and TMR_FIRED (timeout reported). Its transitions are:
- arm: TMR_IDLE to TMR_RUN, when the next fill is non-empty and below the level.
- restart: TMR_RUN or TMR_FIRED to TMR_RUN, when a byte arrives or an acknowledge is written.
- expire: TMR_RUN to TMR_FIRED, when the idle count equals the limit.
- disarm: any state to TMR_IDLE, when the next fill is empty, is at or above the level, or the limit is zero.

Top module: `rxwin_fifo`

## Requirements
- R1: After reset the fill count is 0 and data_avail, char_timeout and overrun are all 0.
- R2: A strobe on `in_valid` while the fill count is below 1024 stores the byte and raises the fill count by one in the next cycle.
- R3: A window read at offset k, with 4 ≤ k ≤ 1023, returns the byte k−4 places after the oldest unread byte, one cycle after the read strobe. Offsets 0 to 3 return 0x00.
- R4: Writing N on `ack_wr` releases N bytes. The oldest unread byte becomes the one N places further on, wrapping around the 1024-entry store.
- R5: An acknowledge value larger than the fill count releases only the bytes present, leaving the fill count at 0.
- R6: `data_avail` is 1 exactly while the fill count is ≥ 4·2^code, where code is `cfg_level` (code 0 = 4 bytes, code 7 = 512 bytes).
- R7: With limit T ≠ 0 and divisor B ≥ 1, `char_timeout` rises T·B·4+1 cycles after the cycle of the last accepted byte or acknowledge. This holds only while the fill count stays non-empty and below the trigger level.
- R8: An accepted byte or an acknowledge clears `char_timeout` in the next cycle. The flag never rises while the store is empty or at or above the trigger level. A limit of 0 disables it.
- R9: A byte strobed while the fill count is 1024 is discarded. The fill count stays at 1024, and `overrun` pulses for one cycle.
- R10: With a full store, offset 1023 returns the 1020th unread byte. This is the deepest byte one pass of the window can reach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe from the deserialiser |
| in_byte | input | 8 | Received byte |
| win_rd | input | 1 | Window read strobe |
| win_off | input | 10 | Window byte offset |
| win_data | output | 8 | Window read data, valid the cycle after `win_rd` |
| ack_wr | input | 1 | Acknowledge write strobe |
| ack_cnt | input | 11 | Number of bytes consumed |
| cfg_level | input | 3 | Trigger level code |
| tmo_limit | input | 16 | Idle limit in units of 4·B cycles; 0 disables |
| baud_div | input | 16 | Divisor B of the idle time base |
| fill_count | output | 11 | Bytes currently held |
| data_avail | output | 1 | Fill count at or above the trigger level |
| char_timeout | output | 1 | Idle timeout reported |
| overrun | output | 1 | One-cycle pulse on a dropped byte |

## Verification
The bound checker watches the counting rules on every cycle:
- the fill count never goes past capacity;
- an accepted byte with no acknowledge adds exactly one;
- an oversized acknowledge empties the store;
- overrun appears only after a full cycle;
- the timeout flag appears only while the store holds fewer bytes than the level, and clears after any arrival.

Data ordering through the window, wrap-around after a bulk acknowledge, the exact expiry cycle of the idle timer and the reach limit of one window pass depend on byte values and long stimulus histories. Only the scoreboard scenarios can show those.

// File: rtl/rxwin_pkg.sv
package rxwin_pkg;

    typedef enum logic [1:0] {
        TMR_IDLE  = 2'd0,
        TMR_RUN   = 2'd1,
        TMR_FIRED = 2'd2
    } tmr_state_e;

    // Trigger threshold in bytes for a level code: four times two to the code.
    function automatic logic [15:0] level_bytes(input logic [2:0] code);
        return 16'd4 << code;
    endfunction

endpackage

// File: rtl/rxwin_store.sv
module rxwin_store #(
    parameter int DEPTH    = 1024,
    parameter int WIN_BASE = 4,
    localparam int ADDR_W  = $clog2(DEPTH),
    localparam int CNT_W   = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              rel_req,
    input  logic [CNT_W-1:0]  rel_cnt,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_off,
    output logic [7:0]        rd_data,
    output logic [CNT_W-1:0]  fill,
    output logic [CNT_W-1:0]  fill_nxt,
    output logic              accepted,
    output logic              dropped
);
    logic [7:0]        mem [DEPTH];
    logic [ADDR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0]  fill_q;
    logic [CNT_W-1:0]  rel_amt;
    logic              full;
    logic [ADDR_W-1:0] rd_idx;

    assign full     = (fill_q == CNT_W'(DEPTH));
    assign accepted = in_valid && !full;
    assign rel_amt  = !rel_req ? '0 : ((rel_cnt > fill_q) ? fill_q : rel_cnt);
    assign fill_nxt = fill_q + CNT_W'(accepted) - rel_amt;
    assign rd_idx   = rptr_q + rd_off - ADDR_W'(WIN_BASE);
    assign fill     = fill_q;

    always_ff @(posedge clk) begin
        if (accepted) begin
            mem[wptr_q] <= in_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            fill_q  <= '0;
            dropped <= 1'b0;
            rd_data <= '0;
        end else begin
            if (accepted) begin
                wptr_q <= wptr_q + ADDR_W'(1);
            end
            rptr_q  <= rptr_q + rel_amt[ADDR_W-1:0];
            fill_q  <= fill_nxt;
            dropped <= in_valid && full;
            if (rd_req) begin
                rd_data <= (rd_off < ADDR_W'(WIN_BASE)) ? 8'h00 : mem[rd_idx];
            end
        end
    end
endmodule

// File: rtl/rxwin_timer.sv
module rxwin_timer
    import rxwin_pkg::*;
#(
    parameter int CNT_W  = 11,
    parameter int TMO_W  = 16,
    parameter int BAUD_W = 16,
    localparam int PRE_W = BAUD_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              activity,
    input  logic [CNT_W-1:0]  fill_nxt,
    input  logic [CNT_W-1:0]  level,
    input  logic [TMO_W-1:0]  tmo_val,
    input  logic [BAUD_W-1:0] baud_val,
    output logic              fired
);
    tmr_state_e        state_q, state_d;
    logic [PRE_W-1:0]  pre_q;
    logic [PRE_W-1:0]  pre_last;
    logic [TMO_W-1:0]  idle_q;
    logic              armed_ok;
    logic              restart;

    assign pre_last = {baud_val, 2'b00} - PRE_W'(1);
    assign armed_ok = (fill_nxt != '0) && (fill_nxt < level) && (tmo_val != '0);

    always_comb begin
        state_d = state_q;
        restart = 1'b0;
        unique case (state_q)
            TMR_IDLE: begin
                if (armed_ok) begin
                    state_d = TMR_RUN;
                    restart = 1'b1;
                end
            end
            TMR_RUN: begin
                if (!armed_ok) begin
                    state_d = TMR_IDLE;
                end else if (activity) begin
                    restart = 1'b1;
                end else if (idle_q == tmo_val) begin
                    state_d = TMR_FIRED;
                end
            end
            TMR_FIRED: begin
                if (!armed_ok) begin
                    state_d = TMR_IDLE;
                end else if (activity) begin
                    state_d = TMR_RUN;
                    restart = 1'b1;
                end
            end
            default: state_d = TMR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            pre_q   <= '0;
            idle_q  <= '0;
        end else begin
            state_q <= state_d;
            if (restart || state_q != TMR_RUN) begin
                pre_q  <= '0;
                idle_q <= '0;
            end else if (pre_q == pre_last) begin
                pre_q  <= '0;
                idle_q <= idle_q + TMO_W'(1);
            end else begin
                pre_q  <= pre_q + PRE_W'(1);
            end
        end
    end

    always_comb begin
        fired = (state_q == TMR_FIRED);
    end
endmodule

// File: rtl/rxwin_fifo.sv
module rxwin_fifo
    import rxwin_pkg::*;
#(
    parameter int DEPTH    = 1024,
    parameter int WIN_BASE = 4,
    parameter int LVL_W    = 3,
    parameter int TMO_W    = 16,
    parameter int BAUD_W   = 16,
    localparam int ADDR_W  = $clog2(DEPTH),
    localparam int CNT_W   = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              win_rd,
    input  logic [ADDR_W-1:0] win_off,
    output logic [7:0]        win_data,
    input  logic              ack_wr,
    input  logic [CNT_W-1:0]  ack_cnt,
    input  logic [LVL_W-1:0]  cfg_level,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic [BAUD_W-1:0] baud_div,
    output logic [CNT_W-1:0]  fill_count,
    output logic              data_avail,
    output logic              char_timeout,
    output logic              overrun
);
    logic [CNT_W-1:0] fill_nxt;
    logic [CNT_W-1:0] level;
    logic             accepted;
    logic [15:0]      lvl_full;

    assign lvl_full = level_bytes(3'(cfg_level));
    assign level    = lvl_full[CNT_W-1:0];

    rxwin_store #(.DEPTH(DEPTH), .WIN_BASE(WIN_BASE)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .rel_req  (ack_wr),
        .rel_cnt  (ack_cnt),
        .rd_req   (win_rd),
        .rd_off   (win_off),
        .rd_data  (win_data),
        .fill     (fill_count),
        .fill_nxt (fill_nxt),
        .accepted (accepted),
        .dropped  (overrun)
    );

    rxwin_timer #(.CNT_W(CNT_W), .TMO_W(TMO_W), .BAUD_W(BAUD_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .activity (accepted || ack_wr),
        .fill_nxt (fill_nxt),
        .level    (level),
        .tmo_val  (tmo_limit),
        .baud_val (baud_div),
        .fired    (char_timeout)
    );

    assign data_avail = (fill_count >= level);
endmodule

// File: rtl/rxwin_fifo_chk.sv
module rxwin_fifo_chk #(
    parameter int DEPTH = 1024,
    parameter int CNT_W = 11,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             ack_wr,
    input logic [CNT_W-1:0] ack_cnt,
    input logic [LVL_W-1:0] cfg_level,
    input logic [CNT_W-1:0] fill_count,
    input logic             data_avail,
    input logic             char_timeout,
    input logic             overrun
);
    // R9
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(DEPTH));

    // R2
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fill_count < CNT_W'(DEPTH) && !ack_wr)
        |=> fill_count == $past(fill_count) + CNT_W'(1));

    // R5
    ack_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !in_valid && ack_cnt >= fill_count) |=> fill_count == '0);

    // R9
    ovr_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(fill_count) == CNT_W'(DEPTH));

    // R8
    tmo_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_timeout && $stable(cfg_level)) |-> (fill_count != '0 && !data_avail));

    // R8
    tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr || (in_valid && fill_count < CNT_W'(DEPTH))) |=> !char_timeout);
endmodule

bind rxwin_fifo rxwin_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .ack_wr       (ack_wr),
    .ack_cnt      (ack_cnt),
    .cfg_level    (cfg_level),
    .fill_count   (fill_count),
    .data_avail   (data_avail),
    .char_timeout (char_timeout),
    .overrun      (overrun)
);

// File: tb/tb_rxwin_fifo.sv
module tb_rxwin_fifo;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_valid = 0;
    logic [7:0]  in_byte = 0;
    logic        win_rd = 0;
    logic [9:0]  win_off = 0;
    logic [7:0]  win_data;
    logic        ack_wr = 0;
    logic [10:0] ack_cnt = 0;
    logic [2:0]  cfg_level = 3'd7;
    logic [15:0] tmo_limit = 0;
    logic [15:0] baud_div = 16'd1;
    logic [10:0] fill_count;
    logic        data_avail, char_timeout, overrun;

    int errors = 0;
    int checks = 0;
    byte unsigned model_q[$];
    byte unsigned exp_q[$];
    string        tag_q[$];
    logic         rd_d = 0;
    bit           done = 0;

    always #10 clk = ~clk;

    rxwin_fifo dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .win_rd(win_rd), .win_off(win_off), .win_data(win_data),
        .ack_wr(ack_wr), .ack_cnt(ack_cnt), .cfg_level(cfg_level),
        .tmo_limit(tmo_limit), .baud_div(baud_div), .fill_count(fill_count),
        .data_avail(data_avail), .char_timeout(char_timeout), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: compares window data one cycle after each read strobe.
    always @(posedge clk) rd_d <= win_rd;
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            byte unsigned e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(win_data == e, t, win_data, e);
        end
    end

    task automatic push_byte(input byte unsigned b);
        in_valid = 1; in_byte = b;
        if (model_q.size() < 1024) model_q.push_back(b);
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic ack(input int n);
        int k;
        ack_wr = 1; ack_cnt = 11'(n);
        k = (n > model_q.size()) ? model_q.size() : n;
        for (int i = 0; i < k; i++) void'(model_q.pop_front());
        @(negedge clk);
        ack_wr = 0;
    endtask

    task automatic win_read(input int off, input string tag);
        win_rd = 1; win_off = 10'(off);
        exp_q.push_back((off < 4) ? 8'h00 : model_q[off-4]);
        tag_q.push_back(tag);
        @(negedge clk);
        win_rd = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(fill_count == 0, "R1 fill", fill_count, 0);
        chk(!data_avail && !char_timeout && !overrun, "R1 flags",
            {data_avail, char_timeout, overrun}, 0);

        for (int i = 0; i < 10; i++) push_byte(8'(i * 7 + 3));
        chk(fill_count == 10, "R2 fill after 10", fill_count, 10);
        for (int off = 4; off < 14; off++) win_read(off, "R3 window order");
        win_read(0, "R3 low offset");
        win_read(3, "R3 low offset");

        ack(3);
        chk(fill_count == 7, "R4 fill after ack", fill_count, 7);
        win_read(4, "R4 read pointer moved");
        win_read(10, "R4 last byte");

        ack(100);
        chk(fill_count == 0, "R5 clamp", fill_count, 0);

        cfg_level = 3'd0;
        for (int i = 0; i < 3; i++) push_byte(8'(8'h40 + i));
        chk(!data_avail, "R6 below level 4", data_avail, 0);
        push_byte(8'h43);
        chk(data_avail, "R6 at level 4", data_avail, 1);
        cfg_level = 3'd1;
        @(negedge clk);
        chk(!data_avail, "R6 below level 8", data_avail, 0);

        // Idle timeout: T=3, B=2 -> 25 cycles after last activity
        tmo_limit = 16'd3; baud_div = 16'd2;
        push_byte(8'h55);
        repeat (24) @(negedge clk);
        chk(!char_timeout, "R7 before expiry", char_timeout, 0);
        @(negedge clk);
        chk(char_timeout, "R7 at expiry", char_timeout, 1);
        ack(1);
        chk(!char_timeout, "R8 cleared by ack", char_timeout, 1'b0);
        repeat (24) @(negedge clk);
        chk(!char_timeout, "R7 restart before expiry", char_timeout, 0);
        @(negedge clk);
        chk(char_timeout, "R7 restart at expiry", char_timeout, 1);
        push_byte(8'h56);
        chk(!char_timeout, "R8 cleared by byte", char_timeout, 0);
        cfg_level = 3'd0;
        repeat (60) @(negedge clk);
        chk(!char_timeout, "R8 at or above level", char_timeout, 0);
        ack(1024);
        repeat (60) @(negedge clk);
        chk(!char_timeout, "R8 empty store", char_timeout, 0);
        tmo_limit = 16'd0;

        cfg_level = 3'd7;
        for (int i = 0; i < 1024; i++) push_byte(8'(i));
        chk(fill_count == 1024, "R9 full", fill_count, 1024);
        in_valid = 1; in_byte = 8'hEE;
        @(negedge clk);
        in_valid = 0;
        chk(overrun, "R9 overrun pulse", overrun, 1);
        chk(fill_count == 1024, "R9 fill held", fill_count, 1024);
        @(negedge clk);
        chk(!overrun, "R9 pulse width", overrun, 0);
        win_read(1023, "R10 deepest byte");
        win_read(4, "R9 oldest kept");

        ack(1000);
        chk(fill_count == 24, "R4 bulk ack", fill_count, 24);
        for (int i = 0; i < 5; i++) push_byte(8'(8'hA0 + i));
        win_read(4, "R4 wrap oldest");
        win_read(28, "R4 wrap new byte");
        win_read(32, "R4 wrap last byte");

        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                chk(0, "watchdog", 0, 1);
            end
        join_any
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule